// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block sits on the device side of a management bus and decides how each host access reaches a large internal register space. The host side is a simple parallel port. Each access carries a device address, a register number, a direction and write data. A five-bit strap input picks the mode. With the strap at zero the bridge is transparent: every access is forwarded to the internal register port, and the answer returns when the register file acknowledges.

With a nonzero strap the device answers only at the strapped address, and it exposes two local registers there. Register 0 is a command register and register 1 is a data register. Host software places data in the data register and then writes a command word. The command word holds an opcode and a target device and register. The bridge raises a busy flag, runs a single internal access, and clears the flag when the register file acknowledges. If no acknowledge arrives within a bounded number of cycles, the bridge abandons the access instead.

Host software polls the busy flag a small, fixed number of times before it gives up. The abandon limit keeps every access within that polling budget, even when the register file never answers.

Top module: `mgmt_tunnel_bridge`

## Requirements
- R1: With `strap_addr` equal to 0, a host access is presented on the internal port in the next cycle with the same device, register, direction and write data. `host_ack` pulses one cycle after `rf_ack`. `host_rdata` then carries `rf_rdata` for a read and 0 for a write.
- R2: With a nonzero strap, an access to any other device address produces no `host_ack` and no internal access. An access at the strap address is acknowledged in the next cycle. Register 0 is the command register and register 1 is the data register. Reads of registers 2 to 31 return 0, and writes to them change nothing.
- R3: A read of the command register returns the last accepted command word, with bit 15 replaced by the busy state at the time of the read.
- R4: In a command word, bits 9:5 hold the target device and bits 4:0 hold the target register. Bits 15:10 equal to 6'b100110 (0x98xx) mean read, and 6'b100101 (0x94xx) mean write. An accepted command sets busy and pulses `rf_req` for one cycle in the next cycle.
- R5: When an indirect read completes, the returned value is loaded into the data register.
- R6: An indirect write stores the value the data register held when the command was accepted. Data register writes made while busy do not alter that value.
- R7: A command written while busy is ignored. No internal access starts and the command readback is unchanged.
- R8: A command word whose bits 15:10 match neither opcode is ignored. Busy stays 0 and the command readback is unchanged.
- R9: Busy reads 0 from the cycle after the one in which `rf_ack` is seen.
- R10: If `rf_ack` has not arrived after `BUSY_LIMIT` cycles, counted from the `rf_req` cycle, the access is abandoned. An indirect read then loads 0xFFFF into the data register and busy clears. A direct read is acknowledged with 0xFFFF.
- R11: If a host write to the data register falls in the same cycle as an indirect read completion, the completion value is kept.
- R12: After reset, busy, the command register and the data register are 0, and `rf_req` and `host_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Strapped bus address; 0 selects direct mode |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | Host access is a write |
| host_dev | input | 5 | Host device address |
| host_reg | input | 5 | Host register number |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Access answered (one-cycle pulse) |
| host_rdata | output | 16 | Read data, valid with host_ack |
| rf_req | output | 1 | Internal access strobe |
| rf_we | output | 1 | Internal access is a write |
| rf_dev | output | 5 | Internal target device |
| rf_reg | output | 5 | Internal target register |
| rf_wdata | output | 16 | Internal write data |
| rf_ack | input | 1 | Internal access complete |
| rf_rdata | input | 16 | Internal read data, valid with rf_ack |

## Verification
Two of the block's functions can act on the data register in the same cycle: completion of an indirect read and a host write to that register. The bench knows the register-file latency of its stub. It issues a read command, waits exactly that many idle cycles, and then places the data register write in the cycle that carries `rf_ack`. A later read of the data register must return the register-file value and not the host value. The per-clock reference model also judges the collision, as does the directed check tagged R11.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [5:0] OPC_READ  = 6'b100110;
  localparam logic [5:0] OPC_WRITE = 6'b100101;
  localparam logic [DATA_W-1:0] ABORT_DATA = '1;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_READ  = 2'd1,
    CK_WRITE = 2'd2
  } cmd_kind_e;

  function automatic cmd_kind_e cmd_kind(input logic [DATA_W-1:0] w);
    case (w[15:10])
      OPC_READ:  return CK_READ;
      OPC_WRITE: return CK_WRITE;
      default:   return CK_NONE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_dev(input logic [DATA_W-1:0] w);
    return w[9:5];
  endfunction

  function automatic logic [ADDR_W-1:0] cmd_reg(input logic [DATA_W-1:0] w);
    return w[4:0];
  endfunction

  function automatic logic [DATA_W-1:0] cmd_readback(input logic busy,
                                                     input logic [DATA_W-1:0] w);
    return {busy, w[DATA_W-2:0]};
  endfunction
endpackage

// File: rtl/mtb_host_decode.sv
module mtb_host_decode
  import mtb_pkg::*;
(
  input  logic [ADDR_W-1:0] strap,
  input  logic              req,
  input  logic [ADDR_W-1:0] dev,
  input  logic [ADDR_W-1:0] regn,
  output logic              direct_go,
  output logic              local_hit,
  output logic              sel_cmd,
  output logic              sel_data
);
  localparam logic [ADDR_W-1:0] REG_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] REG_DATA = ADDR_W'(1);

  logic strap_zero;
  assign strap_zero = (strap == '0);
  assign direct_go  = req && strap_zero;
  assign local_hit  = req && !strap_zero && (dev == strap);
  assign sel_cmd    = local_hit && (regn == REG_CMD);
  assign sel_data   = local_hit && (regn == REG_DATA);
endmodule

// File: rtl/mtb_wait_timer.sv
module mtb_wait_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= '0;
    else if (active) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = active && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/mtb_tunnel_regs.sv
module mtb_tunnel_regs
  import mtb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic              done_load,
  input  logic [DATA_W-1:0] done_val,
  output logic              busy_q,
  output logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] data_q,
  output logic              accept,
  output cmd_kind_e         accept_kind
);
  assign accept_kind = cmd_kind(wdata);
  assign accept      = cmd_wr && !busy_q && (accept_kind != CK_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cmd_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cmd_q  <= wdata;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  // Completion has priority over a simultaneous host write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  data_q <= '0;
    else if (done && done_load)  data_q <= done_val;
    else if (data_wr)            data_q <= wdata;
  end
endmodule

// File: rtl/mgmt_tunnel_bridge.sv
module mgmt_tunnel_bridge
  import mtb_pkg::*;
#(
  parameter int BUSY_LIMIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_dev,
  input  logic [ADDR_W-1:0] host_reg,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ack,
  output logic [DATA_W-1:0] host_rdata,
  output logic              rf_req,
  output logic              rf_we,
  output logic [ADDR_W-1:0] rf_dev,
  output logic [ADDR_W-1:0] rf_reg,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic              rf_ack,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic direct_go, local_hit, sel_cmd, sel_data;
  logic busy_q, dir_pend, wait_rd_q;
  logic [DATA_W-1:0] cmd_q, data_q;
  cmd_kind_e accept_kind;

  // Named internal events
  logic evt_accept, evt_direct, evt_start, evt_finish, evt_abort;
  logic waiting, expire;
  logic [DATA_W-1:0] fin_val;

  mtb_host_decode u_dec (
    .strap     (strap_addr),
    .req       (host_req),
    .dev       (host_dev),
    .regn      (host_reg),
    .direct_go (direct_go),
    .local_hit (local_hit),
    .sel_cmd   (sel_cmd),
    .sel_data  (sel_data)
  );

  assign evt_direct = direct_go && !dir_pend;
  assign evt_start  = evt_accept || evt_direct;
  assign waiting    = busy_q || dir_pend;
  assign evt_finish = waiting && (rf_ack || expire);
  assign evt_abort  = evt_finish && !rf_ack;
  assign fin_val    = rf_ack ? rf_rdata : ABORT_DATA;

  mtb_wait_timer #(.LIMIT(BUSY_LIMIT)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (evt_start),
    .active (waiting),
    .expire (expire)
  );

  mtb_tunnel_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (sel_cmd && host_we),
    .data_wr     (sel_data && host_we),
    .wdata       (host_wdata),
    .done        (evt_finish && busy_q),
    .done_load   (wait_rd_q),
    .done_val    (fin_val),
    .busy_q      (busy_q),
    .cmd_q       (cmd_q),
    .data_q      (data_q),
    .accept      (evt_accept),
    .accept_kind (accept_kind)
  );

  // Internal register port and wait bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_req    <= 1'b0;
      rf_we     <= 1'b0;
      rf_dev    <= '0;
      rf_reg    <= '0;
      rf_wdata  <= '0;
      dir_pend  <= 1'b0;
      wait_rd_q <= 1'b0;
    end else begin
      rf_req <= evt_start;
      if (evt_accept) begin
        rf_we     <= (accept_kind == CK_WRITE);
        rf_dev    <= cmd_dev(host_wdata);
        rf_reg    <= cmd_reg(host_wdata);
        rf_wdata  <= data_q;
        wait_rd_q <= (accept_kind == CK_READ);
      end else if (evt_direct) begin
        rf_we     <= host_we;
        rf_dev    <= host_dev;
        rf_reg    <= host_reg;
        rf_wdata  <= host_wdata;
        wait_rd_q <= !host_we;
      end
      if (evt_direct)                  dir_pend <= 1'b1;
      else if (evt_finish && dir_pend) dir_pend <= 1'b0;
    end
  end

  // Host response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack <= local_hit || (evt_finish && dir_pend);
      if (evt_finish && dir_pend)
        host_rdata <= wait_rd_q ? fin_val : '0;
      else if (sel_cmd && !host_we)
        host_rdata <= cmd_readback(busy_q, cmd_q);
      else if (sel_data && !host_we)
        host_rdata <= data_q;
      else
        host_rdata <= '0;
    end
  end
endmodule

// File: rtl/mtb_bridge_checker.sv
module mtb_bridge_checker #(
  parameter int LIMIT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] strap_addr,
  input logic       host_req,
  input logic [4:0] host_dev,
  input logic       host_ack,
  input logic       rf_req,
  input logic       busy_q,
  input logic       dir_pend,
  input logic       evt_accept,
  input logic       evt_finish
);
  localparam int RW = $clog2(LIMIT + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  a_r1_direct_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && strap_addr == 5'd0 && !dir_pend) |=> rf_req);

  a_r2_silent_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && strap_addr != 5'd0 && host_dev != strap_addr) |=> !host_ack);

  a_r4_req_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    evt_accept |=> (rf_req && busy_q));

  a_r4_req_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |=> !rf_req);

  a_r7_no_accept_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !evt_accept);

  a_r9_idle_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_finish && busy_q) |=> !busy_q);

  a_r10_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (run_q < RW'(LIMIT)));
endmodule

bind mgmt_tunnel_bridge mtb_bridge_checker #(.LIMIT(BUSY_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap_addr (strap_addr),
  .host_req   (host_req),
  .host_dev   (host_dev),
  .host_ack   (host_ack),
  .rf_req     (rf_req),
  .busy_q     (busy_q),
  .dir_pend   (dir_pend),
  .evt_accept (evt_accept),
  .evt_finish (evt_finish)
);

// File: tb/mgmt_tunnel_bridge_bench.sv
module mgmt_tunnel_bridge_bench;
  localparam int LIMIT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  strap = 5'd0;
  logic        h_req = 1'b0, h_we = 1'b0;
  logic [4:0]  h_dev = '0, h_reg = '0;
  logic [15:0] h_wd = '0;
  logic        host_ack;
  logic [15:0] host_rdata;
  logic        rf_req, rf_we;
  logic [4:0]  rf_dev, rf_reg;
  logic [15:0] rf_wdata;
  logic        rf_ack = 1'b0;
  logic [15:0] rf_rdata = '0;

  always #2 clk = ~clk;

  mgmt_tunnel_bridge #(.BUSY_LIMIT(LIMIT)) u_mgmt_tunnel_bridge (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap),
    .host_req(h_req), .host_we(h_we), .host_dev(h_dev), .host_reg(h_reg),
    .host_wdata(h_wd), .host_ack(host_ack), .host_rdata(host_rdata),
    .rf_req(rf_req), .rf_we(rf_we), .rf_dev(rf_dev), .rf_reg(rf_reg),
    .rf_wdata(rf_wdata), .rf_ack(rf_ack), .rf_rdata(rf_rdata)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string tag = "R12";

  // Stub register file
  logic [15:0] mem [0:31][0:31];
  int lat = 2;
  bit mute = 0;
  int st_cnt = -1;
  logic st_we;
  logic [4:0] st_dev, st_reg;
  logic [15:0] st_wd;

  function automatic logic [15:0] init_val(int d, int r);
    return 16'((d * 16'h0451) ^ (r * 16'h0107) ^ 16'h3C00);
  endfunction

  // Reference model state
  bit m_busy, m_pend, m_rd;
  int m_wcnt;
  logic [15:0] m_cmd, m_data;
  bit e_ack, e_rreq, e_rwe;
  logic [15:0] e_rdata, e_rwd;
  logic [4:0] e_rdev, e_rreg;

  task automatic model_step();
    bit go, hit, waiting, expire, fin, is_rd, is_wr, accept;
    logic [15:0] fv;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_rd = 0; m_wcnt = 0; m_cmd = 0; m_data = 0;
      e_ack = 0; e_rreq = 0; e_rdata = 0;
      return;
    end
    go      = h_req && strap == 0 && !m_pend;
    hit     = h_req && strap != 0 && h_dev == strap;
    waiting = m_busy || m_pend;
    expire  = waiting && m_wcnt == LIMIT - 1;
    fin     = waiting && (rf_ack || expire);
    fv      = rf_ack ? rf_rdata : 16'hFFFF;
    is_rd   = h_wd[15:10] == 6'h26;
    is_wr   = h_wd[15:10] == 6'h25;
    accept  = hit && h_we && h_reg == 0 && !m_busy && (is_rd || is_wr);
    e_ack   = hit || (fin && m_pend);
    if (fin && m_pend)              e_rdata = m_rd ? fv : 16'h0;
    else if (hit && !h_we && h_reg == 0) e_rdata = {m_busy, m_cmd[14:0]};
    else if (hit && !h_we && h_reg == 1) e_rdata = m_data;
    else                            e_rdata = 16'h0;
    e_rreq = accept || go;
    if (accept) begin
      e_rwe = is_wr; e_rdev = h_wd[9:5]; e_rreg = h_wd[4:0]; e_rwd = m_data;
    end else if (go) begin
      e_rwe = h_we; e_rdev = h_dev; e_rreg = h_reg; e_rwd = h_wd;
    end
    if (fin && m_busy && m_rd)            m_data = fv;
    else if (hit && h_we && h_reg == 1)   m_data = h_wd;
    if (accept || go) m_wcnt = 0; else if (waiting) m_wcnt++;
    if (accept) m_rd = is_rd; else if (go) m_rd = !h_we;
    if (accept) m_cmd = h_wd;
    if (accept) m_busy = 1; else if (fin && m_busy) m_busy = 0;
    if (go) m_pend = 1; else if (fin && m_pend) m_pend = 0;
  endtask

  task automatic cmp16(string what, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic chk(string rq, string what, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic stub_step();
    rf_ack = 0;
    if (!rst_n) begin st_cnt = -1; return; end
    if (st_cnt > 0) st_cnt--;
    if (st_cnt == 0) begin
      st_cnt = -1;
      if (!mute) begin
        rf_ack = 1;
        rf_rdata = st_we ? 16'h0 : mem[st_dev][st_reg];
        if (st_we) mem[st_dev][st_reg] = st_wd;
      end
    end
    if (rf_req) begin
      st_cnt = lat; st_we = rf_we; st_dev = rf_dev; st_reg = rf_reg; st_wd = rf_wdata;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp16("rf_req", {15'd0, rf_req}, {15'd0, e_rreq});
    if (e_rreq) begin
      cmp16("rf_we", {15'd0, rf_we}, {15'd0, e_rwe});
      cmp16("rf_addr", {6'd0, rf_dev, rf_reg}, {6'd0, e_rdev, e_rreg});
      cmp16("rf_wdata", rf_wdata, e_rwd);
    end
    cmp16("host_ack", {15'd0, host_ack}, {15'd0, e_ack});
    if (e_ack) cmp16("host_rdata", host_rdata, e_rdata);
    stub_step();
  endtask

  task automatic host_op(bit we, logic [4:0] d, logic [4:0] r, logic [15:0] v);
    h_req = 1; h_we = we; h_dev = d; h_reg = r; h_wd = v;
    cyc();
    h_req = 0; h_we = 0;
  endtask

  task automatic wait_ack();
    for (int i = 0; i < 20 && !host_ack; i++) cyc();
  endtask

  task automatic poll_idle(output int n);
    bit free = 0;
    n = 0;
    for (int i = 0; i < 16 && !free; i++) begin
      host_op(0, strap, 5'd0, 16'h0);
      n++;
      free = !host_rdata[15];
    end
  endtask

  task automatic do_reset(logic [4:0] s);
    rst_n = 0; strap = s;
    cyc(); cyc();
    rst_n = 1;
    cyc();
  endtask

  initial begin
    int n;
    logic [15:0] c;
    for (int d = 0; d < 32; d++)
      for (int r = 0; r < 32; r++) mem[d][r] = init_val(d, r);

    // Direct mode
    lat = 2;
    do_reset(5'd0);
    tag = "R12";
    chk("R12", "rf_req after reset", {15'd0, rf_req}, 16'd0);
    chk("R12", "host_ack after reset", {15'd0, host_ack}, 16'd0);
    tag = "R1";
    host_op(1, 5'd3, 5'd7, 16'hBEEF); wait_ack();
    chk("R1", "direct write ack data", host_rdata, 16'h0);
    cyc();
    host_op(0, 5'd3, 5'd7, 16'h0); wait_ack();
    chk("R1", "direct read back", host_rdata, 16'hBEEF);
    cyc();
    host_op(0, 5'd31, 5'd31, 16'h0); wait_ack();
    chk("R1", "direct read far corner", host_rdata, init_val(31, 31));
    cyc();
    tag = "R10"; mute = 1;
    host_op(0, 5'd4, 5'd4, 16'h0); wait_ack();
    chk("R10", "direct abort data", host_rdata, 16'hFFFF);
    mute = 0; cyc();

    // Indirect mode
    lat = 3;
    do_reset(5'd5);
    tag = "R12";
    host_op(0, 5'd5, 5'd0, 16'h0);
    chk("R12", "cmd reg after reset", host_rdata, 16'h0);
    host_op(0, 5'd5, 5'd1, 16'h0);
    chk("R12", "data reg after reset", host_rdata, 16'h0);
    tag = "R2";
    host_op(0, 5'd6, 5'd0, 16'h0);
    chk("R2", "no ack off-address", {15'd0, host_ack}, 16'd0);
    host_op(1, 5'd4, 5'd1, 16'h1234);
    chk("R2", "no ack off-address write", {15'd0, host_ack}, 16'd0);
    host_op(1, 5'd5, 5'd9, 16'h5555);
    host_op(0, 5'd5, 5'd9, 16'h0);
    chk("R2", "spare register reads 0", host_rdata, 16'h0);
    host_op(0, 5'd5, 5'd1, 16'h0);
    chk("R2", "data untouched by others", host_rdata, 16'h0);
    host_op(1, 5'd5, 5'd1, 16'hA5A5);
    host_op(0, 5'd5, 5'd1, 16'h0);
    chk("R2", "data reg readback", host_rdata, 16'hA5A5);

    tag = "R6";
    host_op(1, 5'd5, 5'd0, 16'h9449);            // write dev2 reg9
    host_op(0, 5'd5, 5'd0, 16'h0);
    chk("R3", "cmd readback while busy", host_rdata, 16'h9449);
    host_op(1, 5'd5, 5'd1, 16'h0F0F);            // data write while busy
    tag = "R7";
    host_op(1, 5'd5, 5'd0, 16'h9863);            // ignored: busy
    poll_idle(n);
    chk("R3", "cmd readback idle", host_rdata, 16'h1449);
    chk("R6", "write used data at accept", mem[2][9], 16'hA5A5);
    chk("R7", "busy command left dev3 reg3", mem[3][3], init_val(3, 3));

    tag = "R4";
    host_op(1, 5'd5, 5'd1, 16'h6D6D);
    host_op(1, 5'd5, 5'd0, 16'h9400 | (16'd17 << 5) | 16'd30);
    poll_idle(n);
    chk("R4", "field decode dev17 reg30", mem[17][30], 16'h6D6D);

    tag = "R9";
    c = 16'h9800 | (16'd7 << 5) | 16'd3;
    host_op(1, 5'd5, 5'd0, c);
    poll_idle(n);
    chk("R9", "polls until idle", 16'(n), 16'(lat + 2));
    tag = "R5";
    host_op(0, 5'd5, 5'd1, 16'h0);
    chk("R5", "read result in data reg", host_rdata, init_val(7, 3));

    tag = "R8";
    host_op(1, 5'd5, 5'd0, 16'hC0E3);
    host_op(0, 5'd5, 5'd0, 16'h0);
    chk("R8", "bad opcode ignored", host_rdata, c & 16'h7FFF);

    tag = "R11";
    host_op(1, 5'd5, 5'd1, 16'h0000);
    c = 16'h9800 | (16'd12 << 5) | 16'd20;
    host_op(1, 5'd5, 5'd0, c);
    for (int i = 0; i < lat; i++) cyc();
    host_op(1, 5'd5, 5'd1, 16'h7777);            // lands with rf_ack
    poll_idle(n);
    host_op(0, 5'd5, 5'd1, 16'h0);
    chk("R11", "completion wins collision", host_rdata, init_val(12, 20));

    tag = "R10"; mute = 1;
    host_op(1, 5'd5, 5'd0, 16'h9800 | (16'd1 << 5) | 16'd1);
    for (int i = 0; i < LIMIT + 2; i++) cyc();
    host_op(0, 5'd5, 5'd1, 16'h0);
    chk("R10", "abort loads all ones", host_rdata, 16'hFFFF);
    host_op(0, 5'd5, 5'd0, 16'h0);
    chk("R10", "busy clear after abort", {15'd0, host_rdata[15]}, 16'd0);
    mute = 0;

    // Other latencies, other strap
    for (int l = 1; l <= 4; l += 3) begin
      lat = l;
      do_reset(5'd31);
      tag = "R4";
      host_op(1, 5'd31, 5'd1, 16'(16'h0C00 + l));
      host_op(1, 5'd31, 5'd0, 16'h9400 | (16'd9 << 5) | 16'd2);
      poll_idle(n);
      chk("R9", "polls until idle", 16'(n), 16'(l + 2));
      host_op(1, 5'd31, 5'd0, 16'h9800 | (16'd9 << 5) | 16'd2);
      poll_idle(n);
      host_op(0, 5'd31, 5'd1, 16'h0);
      chk("R5", "round trip", host_rdata, 16'(16'h0C00 + l));
    end

    cyc(); cyc();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule